// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Carry and Overflow Flags

This block is one registered stage of an integer datapath. It adds, subtracts, negates or compares two operands and returns the result with a condition field and a set of status flags. The second operand is either a register value or a sign-extended immediate. Carry and overflow are each reported twice: once for the full word and once for the low half-word, which is the low `LOW` bits.

Each operation updates only its own subset of the flags. The unit therefore also drives a write-enable for the carry pair, for the overflow pair and for summary-overflow. A flag whose write-enable is low leaves the stage carrying the value that came in, so downstream state tracking can ignore it. All outputs are registered and appear one clock after the inputs are taken.

Top module: `addflag_unit`

## Requirements
- R1: While `rst_n` is low, every output is driven to zero.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge. Opcode encodings are: 0 add (a+b), 1 subtract-from (b+~a+1), 2 negate (~a+1), 3 add carrying, 4 subtract-from carrying, 5 extended add (a+b+ca_i), 6 extended subtract-from (b+~a+ca_i), 7 alternate-carry add (a+b+ca_i), 8 compare (result a+~b+1).
- R3: When `use_imm_i` is 1, the second operand is `imm_i` sign-extended to `WIDTH` bits in place of `b_i`.
- R4: For opcodes 0 to 6 with `oe_i`=1, `ov_o[1]` is the carry out of bit WIDTH-1 XOR the carry into bit WIDTH-1, and `ov_we_o`=1.
- R5: `ov_o[0]` and `ca_o[0]` follow the same rules as bit 1, evaluated at bit LOW-1 instead of bit WIDTH-1.
- R6: Opcodes 3 to 6 set `ca_we_o`=1 and `ca_o[1]` to the carry out of bit WIDTH-1. Every other operation gives `ca_we_o`=0 and `ca_o`={ca_i,ca_i}.
- R7: The extended forms (5, 6) use `ca_i` as the carry into bit 0.
- R8: For opcodes 0 to 6 with `oe_i`=0, `ov_we_o`=0, `so_we_o`=0, `ov_o`=0 and `so_o`=`so_i`.
- R9: `so_o` = `so_i` OR (`ov_we_o` AND `ov_o[1]`), so summary-overflow is sticky. `so_we_o` equals `ov_we_o`.
- R10: Opcode 7 with `alt_sel_i`=0 gives `ov_we_o`=1 and `ov_o`={carry out of bit WIDTH-1, carry out of bit LOW-1}, whatever `oe_i` is. With any other select value it writes no flag.
- R11: Compare (8) writes no carry, overflow or summary-overflow flag. It sets `cr_o`={a<b, a>b, a==b, so_i}, using a signed comparison when `cmp_signed_i`=1 and an unsigned one otherwise.
- R12: For every other opcode, `cr_o`={result negative, result positive, result zero, so_o}, with the result read as a signed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Opcode (encoding in R2) |
| oe_i | input | 1 | Overflow enable |
| alt_sel_i | input | 2 | Select field of the alternate-carry add |
| cmp_signed_i | input | 1 | Compare is signed when 1 |
| use_imm_i | input | 1 | Take the immediate as the second operand |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (register) |
| imm_i | input | IMMW | Immediate, sign-extended |
| so_i | input | 1 | Incoming summary-overflow |
| ca_i | input | 1 | Incoming carry |
| result_o | output | WIDTH | Result |
| cr_o | output | 4 | Condition field {neg/lt, pos/gt, zero/eq, so} |
| so_o | output | 1 | Summary-overflow |
| ca_o | output | 2 | Carry {full, low} |
| ov_o | output | 2 | Overflow {full, low} |
| ca_we_o | output | 1 | Carry pair write-enable |
| ov_we_o | output | 1 | Overflow pair write-enable |
| so_we_o | output | 1 | Summary-overflow write-enable |

## Verification
The assertions assume the opcode input holds one of the nine defined encodings in every cycle after reset. Undefined codes are treated as operations that write no flag, and no property covers them. The stimulus only loops over the defined opcodes. It varies `oe_i`, the select field, signedness and `so_i` from operand bits, so each flag rule is exercised both with its write-enable high and with it low.

// File: rtl/addflag_pkg.sv
package addflag_pkg;
   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_SUBF  = 4'd1,
      OP_NEG   = 4'd2,
      OP_ADDC  = 4'd3,
      OP_SUBFC = 4'd4,
      OP_ADDE  = 4'd5,
      OP_SUBFE = 4'd6,
      OP_ALT   = 4'd7,
      OP_CMP   = 4'd8
   } addflag_op_e;

   typedef struct packed {
      logic [3:0] cr;
      logic       so;
      logic [1:0] ca;
      logic [1:0] ov;
      logic       ca_we;
      logic       ov_we;
      logic       so_we;
   } addflag_flags_t;
endpackage

// File: rtl/addflag_operands.sv
module addflag_operands
   import addflag_pkg::*;
#(
   parameter int WIDTH = 64,
   parameter int IMMW  = 16
) (
   input  logic [3:0]       op,
   input  logic             use_imm,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [IMMW-1:0]  imm,
   input  logic             ca_in,
   output logic [WIDTH-1:0] x,
   output logic [WIDTH-1:0] y,
   output logic             cin,
   output logic [WIDTH-1:0] bsel
);
   localparam int EXTW = WIDTH - IMMW;

   generate
      if (EXTW > 0) begin : g_ext
         assign bsel = use_imm ? {{EXTW{imm[IMMW-1]}}, imm} : b;
      end else begin : g_noext
         assign bsel = use_imm ? imm : b;
      end
   endgenerate

   always_comb begin
      x   = a;
      y   = bsel;
      cin = 1'b0;
      case (op)
         OP_SUBF, OP_SUBFC: begin x = ~a; cin = 1'b1;  end
         OP_NEG:            begin x = ~a; y = '0; cin = 1'b1; end
         OP_ADDE, OP_ALT:   begin cin = ca_in;           end
         OP_SUBFE:          begin x = ~a; cin = ca_in;   end
         OP_CMP:            begin y = ~bsel; cin = 1'b1; end
         default:           ;
      endcase
   end
endmodule

// File: rtl/addflag_core.sv
module addflag_core #(
   parameter int WIDTH = 64,
   parameter int LOW   = 32
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout_top,
   output logic             cin_top,
   output logic             cout_low,
   output logic             cin_low
);
   logic [WIDTH:0]   full;
   logic [WIDTH-1:0] cinto;

   assign full = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
   assign sum  = full[WIDTH-1:0];

   for (genvar i = 0; i < WIDTH; i++) begin : g_cin
      assign cinto[i] = full[i] ^ x[i] ^ y[i];
   end

   assign cout_top = full[WIDTH];
   assign cin_top  = cinto[WIDTH-1];
   assign cout_low = cinto[LOW];
   assign cin_low  = cinto[LOW-1];
endmodule

// File: rtl/addflag_flags.sv
module addflag_flags
   import addflag_pkg::*;
#(
   parameter int WIDTH = 64
) (
   input  logic [3:0]       op,
   input  logic             oe,
   input  logic [1:0]       alt_sel,
   input  logic             cmp_signed,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] bsel,
   input  logic [WIDTH-1:0] sum,
   input  logic             cout_top,
   input  logic             cin_top,
   input  logic             cout_low,
   input  logic             cin_low,
   input  logic             so_in,
   input  logic             ca_in,
   output addflag_flags_t   fl
);
   logic is_arith, is_carry, is_alt0, is_cmp;
   logic [1:0] ov_val;
   logic lt, gt, eq, neg, zero;

   assign is_arith = (op <= OP_SUBFE);
   assign is_carry = (op >= OP_ADDC) && (op <= OP_SUBFE);
   assign is_alt0  = (op == OP_ALT) && (alt_sel == 2'd0);
   assign is_cmp   = (op == OP_CMP);

   assign ov_val = is_alt0 ? {cout_top, cout_low}
                           : {cout_top ^ cin_top, cout_low ^ cin_low};

   assign eq  = (a == bsel);
   assign lt  = cmp_signed ? ($signed(a) < $signed(bsel)) : (a < bsel);
   assign gt  = !lt && !eq;
   assign neg  = sum[WIDTH-1];
   assign zero = (sum == '0);

   always_comb begin
      fl.ov_we = (is_arith && oe) || is_alt0;
      fl.so_we = fl.ov_we;
      fl.ca_we = is_carry;
      fl.ov    = fl.ov_we ? ov_val : 2'b00;
      fl.ca    = fl.ca_we ? {cout_top, cout_low} : {ca_in, ca_in};
      fl.so    = so_in || (fl.ov_we && ov_val[1]);
      if (is_cmp) fl.cr = {lt, gt, eq, so_in};
      else        fl.cr = {neg, !neg && !zero, zero, fl.so};
   end
endmodule

// File: rtl/addflag_unit.sv
module addflag_unit
   import addflag_pkg::*;
#(
   parameter int WIDTH = 64,
   parameter int LOW   = 32,
   parameter int IMMW  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_i,
   input  logic             oe_i,
   input  logic [1:0]       alt_sel_i,
   input  logic             cmp_signed_i,
   input  logic             use_imm_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [IMMW-1:0]  imm_i,
   input  logic             so_i,
   input  logic             ca_i,
   output logic [WIDTH-1:0] result_o,
   output logic [3:0]       cr_o,
   output logic             so_o,
   output logic [1:0]       ca_o,
   output logic [1:0]       ov_o,
   output logic             ca_we_o,
   output logic             ov_we_o,
   output logic             so_we_o
);
   generate
      if (LOW < 2 || LOW >= WIDTH) begin : g_bad_low
         $error("addflag_unit: LOW must lie in 2..WIDTH-1");
      end
      if (IMMW < 1 || IMMW > WIDTH) begin : g_bad_imm
         $error("addflag_unit: IMMW must lie in 1..WIDTH");
      end
   endgenerate

   logic [WIDTH-1:0] x, y, bsel, sum;
   logic             cin, cout_top, cin_top, cout_low, cin_low;
   addflag_flags_t   fl, fl_q;

   addflag_operands #(.WIDTH(WIDTH), .IMMW(IMMW)) u_ops (
      .op(op_i), .use_imm(use_imm_i), .a(a_i), .b(b_i), .imm(imm_i),
      .ca_in(ca_i), .x(x), .y(y), .cin(cin), .bsel(bsel));

   addflag_core #(.WIDTH(WIDTH), .LOW(LOW)) u_core (
      .x(x), .y(y), .cin(cin), .sum(sum), .cout_top(cout_top),
      .cin_top(cin_top), .cout_low(cout_low), .cin_low(cin_low));

   addflag_flags #(.WIDTH(WIDTH)) u_flags (
      .op(op_i), .oe(oe_i), .alt_sel(alt_sel_i), .cmp_signed(cmp_signed_i),
      .a(a_i), .bsel(bsel), .sum(sum), .cout_top(cout_top), .cin_top(cin_top),
      .cout_low(cout_low), .cin_low(cin_low), .so_in(so_i), .ca_in(ca_i),
      .fl(fl));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= '0;
         fl_q     <= '0;
      end else begin
         result_o <= sum;
         fl_q     <= fl;
      end
   end

   assign cr_o    = fl_q.cr;
   assign so_o    = fl_q.so;
   assign ca_o    = fl_q.ca;
   assign ov_o    = fl_q.ov;
   assign ca_we_o = fl_q.ca_we;
   assign ov_we_o = fl_q.ov_we;
   assign so_we_o = fl_q.so_we;
endmodule

// File: rtl/addflag_checker.sv
module addflag_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] op_i,
   input logic       oe_i,
   input logic       so_i,
   input logic       ca_i,
   input logic       so_o,
   input logic [1:0] ca_o,
   input logic [1:0] ov_o,
   input logic       ca_we_o,
   input logic       ov_we_o,
   input logic       so_we_o
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   // R11: compare leaves carry, overflow and summary-overflow alone
   a_r11_cmp_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      ($past(op_i) == 4'd8) |-> (!ca_we_o && !ov_we_o && so_o == $past(so_i)));

   // R9: summary-overflow never drops once it came in set
   a_r9_sticky_so: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $past(so_i) |-> so_o);

   // R9: a written overflow of one sets summary-overflow
   a_r9_ov_sets_so: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (ov_we_o && ov_o[1]) |-> (so_o && so_we_o));

   // R8: no overflow write without overflow enable
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      ($past(op_i) <= 4'd6 && !$past(oe_i)) |-> (!ov_we_o && ov_o == 2'b00 && so_o == $past(so_i)));

   // R6: unwritten carry pair passes the incoming carry through
   a_r6_carry_kept: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      !ca_we_o |-> (ca_o == {2{$past(ca_i)}}));
endmodule

bind addflag_unit addflag_checker u_addflag_checker (
   .clk(clk), .rst_n(rst_n), .op_i(op_i), .oe_i(oe_i), .so_i(so_i), .ca_i(ca_i),
   .so_o(so_o), .ca_o(ca_o), .ov_o(ov_o), .ca_we_o(ca_we_o),
   .ov_we_o(ov_we_o), .so_we_o(so_we_o));

// File: tb/addflag_unit_bench.sv
module addflag_unit_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int L = 4;
   localparam int IW = 4;
   localparam int M = (1 << W) - 1;

   logic clk = 0;
   logic rst_n = 0;
   logic [3:0]   op_i = 0;
   logic         oe_i = 0, cmp_signed_i = 0, use_imm_i = 0, so_i = 0, ca_i = 0;
   logic [1:0]   alt_sel_i = 0;
   logic [W-1:0] a_i = 0, b_i = 0;
   logic [IW-1:0] imm_i = 0;
   logic [W-1:0] result_o;
   logic [3:0]   cr_o;
   logic         so_o, ca_we_o, ov_we_o, so_we_o;
   logic [1:0]   ca_o, ov_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addflag_unit #(.WIDTH(W), .LOW(L), .IMMW(IW)) u_addflag_unit (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .oe_i(oe_i), .alt_sel_i(alt_sel_i),
      .cmp_signed_i(cmp_signed_i), .use_imm_i(use_imm_i), .a_i(a_i), .b_i(b_i),
      .imm_i(imm_i), .so_i(so_i), .ca_i(ca_i), .result_o(result_o), .cr_o(cr_o),
      .so_o(so_o), .ca_o(ca_o), .ov_o(ov_o), .ca_we_o(ca_we_o),
      .ov_we_o(ov_we_o), .so_we_o(so_we_o));

   task automatic chk(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d (op %0d a %0d b %0d)",
                  req, what, got, exp, op_i, a_i, b_i);
      end
   endtask

   task automatic run_vec();
      int bv, x, y, c, s, r, co_t, ci_t, co_l, ci_l, sa, sb;
      int e_cr, e_so, e_ca, e_ov, e_cawe, e_ovwe, lt, gt, eq;
      bit arith, carry, alt0;
      string rres, rov;
      // R3: immediate is sign-extended
      bv = use_imm_i ? ((imm_i[IW-1] ? (M << IW) : 0) | int'(imm_i)) & M : int'(b_i);
      x = a_i; y = bv; c = 0;
      case (op_i)
         1, 4: begin x = ~int'(a_i) & M; c = 1; end
         2:    begin x = ~int'(a_i) & M; y = 0; c = 1; end
         5, 7: c = ca_i;
         6:    begin x = ~int'(a_i) & M; c = ca_i; end
         8:    begin y = ~bv & M; c = 1; end
         default: ;
      endcase
      s    = x + y + c;
      r    = s & M;
      co_t = (s >> W) & 1;
      ci_t = (((x & (M >> 1)) + (y & (M >> 1)) + c) >> (W-1)) & 1;
      co_l = (((x & ((1 << L) - 1)) + (y & ((1 << L) - 1)) + c) >> L) & 1;
      ci_l = (((x & ((1 << (L-1)) - 1)) + (y & ((1 << (L-1)) - 1)) + c) >> (L-1)) & 1;
      arith = op_i <= 6;
      carry = op_i >= 3 && op_i <= 6;
      alt0  = op_i == 7 && alt_sel_i == 0;
      e_ovwe = ((arith && oe_i) || alt0) ? 1 : 0;
      e_ov = !e_ovwe ? 0 : alt0 ? (co_t*2 + co_l) : ((co_t^ci_t)*2 + (co_l^ci_l));
      e_cawe = carry ? 1 : 0;
      e_ca = carry ? (co_t*2 + co_l) : (ca_i*3);
      e_so = (so_i || (e_ovwe && (e_ov >> 1))) ? 1 : 0;
      if (op_i == 8) begin
         sa = cmp_signed_i ? (a_i[W-1] ? int'(a_i) - (M+1) : int'(a_i)) : int'(a_i);
         sb = cmp_signed_i ? ((bv >> (W-1)) ? bv - (M+1) : bv) : bv;
         lt = sa < sb; gt = sa > sb; eq = sa == sb;
         e_cr = lt*8 + gt*4 + eq*2 + so_i;
      end else begin
         lt = (r >> (W-1)) & 1; eq = r == 0;
         e_cr = lt*8 + ((!lt && !eq) ? 4 : 0) + eq*2 + e_so;
      end
      rres = use_imm_i ? "R3" : (op_i == 5 || op_i == 6) ? "R7" : "R2";
      rov  = alt0 ? "R10" : (arith && !oe_i) ? "R8" : "R4";
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk(rres, "result", result_o, r);
      chk(op_i == 8 ? "R11" : "R12", "cr", cr_o, e_cr);
      chk("R9", "so", so_o, e_so);
      chk("R9", "so_we", so_we_o, e_ovwe);
      chk(rov, "ov_we", ov_we_o, e_ovwe);
      chk(rov, "ov_full", ov_o[1], e_ov >> 1);
      chk("R5", "ov_low", ov_o[0], e_ov & 1);
      chk("R6", "ca_we", ca_we_o, e_cawe);
      chk("R6", "ca_full", ca_o[1], e_ca >> 1);
      chk("R5", "ca_low", ca_o[0], e_ca & 1);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      a_i = 8'hA5; b_i = 8'h5A; so_i = 1; ca_i = 1; oe_i = 1;
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      // R1: reset state
      chk("R1", "result", result_o, 0);
      chk("R1", "flags", {cr_o, so_o, ca_o, ov_o, ca_we_o, ov_we_o, so_we_o}, 0);
      rst_n = 1;
      for (int op = 0; op <= 8; op++) begin
         for (int a = 0; a <= M; a++) begin
            for (int bi = 0; bi < 16; bi++) begin
               for (int ci = 0; ci < 2; ci++) begin
                  op_i = op[3:0];
                  a_i = a[W-1:0];
                  b_i = (bi * 17) & M;
                  ca_i = ci[0];
                  oe_i = a_i[0] ^ b_i[1];
                  so_i = (a_i[3] & b_i[2]) ^ ci[0];
                  alt_sel_i = {a_i[5], a_i[1]};
                  cmp_signed_i = a_i[2] ^ b_i[0];
                  use_imm_i = 0;
                  run_vec();
               end
            end
         end
      end
      // R3: immediate second operand sweep
      for (int op = 0; op <= 8; op += 8) begin
         for (int a = 0; a <= M; a += 3) begin
            for (int im = 0; im < 16; im++) begin
               op_i = op[3:0]; a_i = a[W-1:0]; imm_i = im[IW-1:0];
               b_i = 8'h3C; use_imm_i = 1; oe_i = 1; so_i = 0; ca_i = 0;
               cmp_signed_i = a_i[0]; alt_sel_i = 0;
               run_vec();
            end
         end
      end
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule